// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for a processor's load/store and fetch paths. It keeps 64 translation slots and compares every one of them against each request at once. A slot holds a virtual page number, the identifier of the address space that owns it, a physical page number, and four attribute flags. A request hits only in a slot whose identifier equals the one currently in force. Several processes can therefore keep live translations side by side, and a context switch needs no flush.

The three most significant address bits split the space into regions. Two regions bypass the slots: each maps kernel addresses straight onto physical memory, one as cacheable and one as uncacheable. The user region and the upper kernel region are translated. A lookup that finds no slot reports a miss, and the refill is left to a software handler. The hardware never walks page tables. Software loads a slot by writing it at an index. It can invalidate one slot, or every slot in a single cycle. A read port lets it inspect any slot.

Top module: `xlat_cache`

## Requirements
- R1: A fill writes the page number, identifier, physical page and flags into the slot named by `fill_idx` and marks the slot valid. From the next cycle the read port returns those values for that index. `rd_flags` bit 3 is dirty, bit 2 is referenced, bit 1 is write permission and bit 0 is no-cache.
- R2: A translated lookup hits when a valid slot holds the request's page number (address bits 31:12) and `cur_asid`. The response appears one cycle after the request, with `rsp_paddr` equal to the slot's physical page followed by address bits 11:0. If several slots match, the lowest index wins.
- R3: A slot whose identifier differs from `cur_asid` never matches. The same page number can therefore live under different identifiers.
- R4: A translated lookup that matches no slot raises `rsp_miss` with `rsp_paddr` zero, and it changes no slot.
- R5: Address bits 31:29 = 100 bypass the slots even when a slot would match. The response is a hit with `rsp_paddr` equal to the address with bits 31:29 cleared, and `rsp_uncached` low.
- R6: Address bits 31:29 = 101 bypass the slots in the same way, with `rsp_uncached` high.
- R7: Address bits 31:29 of 0xx and 11x are translated, and on a hit `rsp_uncached` is the slot's no-cache flag.
- R8: With `lk_user` high, any address whose bit 31 is set raises `rsp_addr_err` and leaves all slots untouched. Kernel accesses never raise it.
- R9: A write lookup that hits a slot lacking write permission raises `rsp_prot_err` and leaves that slot's dirty flag clear.
- R10: A lookup that hits a slot, whether it faults or not, sets that slot's referenced flag. A write hit that has permission also sets the dirty flag.
- R11: `inv_one` clears the valid bit of the slot at `inv_idx`, and later lookups fall to the next matching slot or miss.
- R12: `inv_all` clears every valid bit in one cycle. Per slot, global invalidate beats a fill, and a fill beats a single invalidate.
- R13: Each request produces a response in the next cycle with exactly one of hit, miss, address error and protection error set. Without a request `rsp_valid` and all four outcomes are low.
- R14: While reset is held and after it is released, all slots are invalid and no response is pending. The reset is asserted asynchronously and leaves reset two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | 6 | Identifier of the running address space |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | Request is a store |
| lk_user | input | 1 | Request comes from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Address produced |
| rsp_miss | output | 1 | No slot matched; software refill needed |
| rsp_addr_err | output | 1 | User access outside the user region |
| rsp_prot_err | output | 1 | Store to a slot without write permission |
| rsp_paddr | output | 32 | Physical address (zero unless hit) |
| rsp_uncached | output | 1 | Access must bypass caches |
| fill_en | input | 1 | Load a slot |
| fill_idx | input | 6 | Slot to load |
| fill_vpn | input | 20 | Virtual page number |
| fill_asid | input | 6 | Owning identifier |
| fill_ppn | input | 20 | Physical page number |
| fill_writable | input | 1 | Write permission |
| fill_nocache | input | 1 | Uncacheable page |
| fill_dirty | input | 1 | Initial dirty flag |
| fill_ref | input | 1 | Initial referenced flag |
| inv_one | input | 1 | Invalidate one slot |
| inv_idx | input | 6 | Slot to invalidate |
| inv_all | input | 1 | Invalidate all slots |
| rd_idx | input | 6 | Slot to inspect |
| rd_valid | output | 1 | Inspected slot is valid |
| rd_vpn | output | 20 | Inspected page number |
| rd_asid | output | 6 | Inspected identifier |
| rd_ppn | output | 20 | Inspected physical page |
| rd_flags | output | 4 | Inspected flags {dirty, referenced, writable, no-cache} |

## Verification
Every slot is loaded with a page number, identifier and physical page computed from its index. Odd slots sit in the upper kernel region and even slots in the user region. The sweep then runs every slot in several passes: a user-mode pass, which separates address errors from translation; a wrong-identifier pass, which separates identifier matching from page matching; a kernel read pass, which checks addresses and the cache attribute; and a store pass, which splits protection faults from dirty marking. Flags are read back after each pass, so any stray update to a slot shows. Addresses spread across both direct regions show that the bypass ignores the slots. Overlapping slots, single and global invalidates, and invalidates that collide with fills in the same cycle settle the priority rules.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Region classes picked out by the three top address bits
  typedef enum logic [1:0] {
    SEG_MAPPED   = 2'd0,
    SEG_DIRECT_C = 2'd1,
    SEG_DIRECT_U = 2'd2
  } seg_e;

  // Attribute flags of one slot; packed order matches the read-port field
  typedef struct packed {
    logic dirty;
    logic refd;
    logic wr_ok;
    logic nocache;
  } eflags_t;

endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xlat_seg_decode.sv
module xlat_seg_decode
  import xlat_pkg::*;
(
  input  logic [2:0] top_bits,
  input  logic       user_mode,
  output seg_e       seg,
  output logic       addr_err
);

  always_comb begin
    case (top_bits)
      3'b100:  seg = SEG_DIRECT_C;
      3'b101:  seg = SEG_DIRECT_U;
      default: seg = SEG_MAPPED;
    endcase
    // user mode may only reach the region whose top bit is clear
    addr_err = user_mode & top_bits[2];
  end

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PPN_W   = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  // fill and invalidate
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  logic [ASID_W-1:0]           wr_asid,
  input  logic [PPN_W-1:0]            wr_ppn,
  input  eflags_t                     wr_flags,
  input  logic                        inv_one,
  input  logic [$clog2(ENTRIES)-1:0]  inv_idx,
  input  logic                        inv_all,
  // lookup
  input  logic                        lk_en,
  input  logic                        lk_write,
  input  logic [VPN_W-1:0]            lk_vpn,
  input  logic [ASID_W-1:0]           lk_asid,
  output logic                        hit,
  output logic [PPN_W-1:0]            hit_ppn,
  output eflags_t                     hit_flags,
  // inspection
  input  logic [$clog2(ENTRIES)-1:0]  rd_idx,
  output logic                        rd_valid,
  output logic [VPN_W-1:0]            rd_vpn,
  output logic [ASID_W-1:0]           rd_asid,
  output logic [PPN_W-1:0]            rd_ppn,
  output eflags_t                     rd_flags
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] valid_vec;
  logic [VPN_W-1:0]   vpn_arr   [ENTRIES];
  logic [ASID_W-1:0]  asid_arr  [ENTRIES];
  logic [PPN_W-1:0]   ppn_arr   [ENTRIES];
  eflags_t            flags_arr [ENTRIES];

  logic [IDX_W-1:0]   hit_idx;
  logic               upd_ref;
  logic               upd_dirty;

  // lowest matching index wins
  always_comb begin
    hit_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (match[k]) hit_idx = IDX_W'(k);
    end
  end

  assign hit       = |match;
  assign hit_ppn   = ppn_arr[hit_idx];
  assign hit_flags = flags_arr[hit_idx];
  assign upd_ref   = lk_en & hit;
  assign upd_dirty = upd_ref & lk_write & hit_flags.wr_ok;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic              valid_q, valid_d;
    logic              load;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PPN_W-1:0]  ppn_q;
    eflags_t           flags_q, flags_d;
    logic              touched;

    assign load    = wr_en && (wr_idx == IDX_W'(g));
    assign touched = upd_ref && (hit_idx == IDX_W'(g));

    always_comb begin
      // valid: global invalidate, then fill, then single invalidate
      valid_d = valid_q;
      if (inv_all)                                valid_d = 1'b0;
      else if (load)                              valid_d = 1'b1;
      else if (inv_one && inv_idx == IDX_W'(g))   valid_d = 1'b0;

      flags_d = flags_q;
      if (load) begin
        flags_d = wr_flags;
      end else if (touched) begin
        flags_d.refd = 1'b1;
        if (upd_dirty) flags_d.dirty = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (load) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        ppn_q  <= wr_ppn;
      end
    end

    always_ff @(posedge clk) begin
      if (load || touched) flags_q <= flags_d;
    end

    assign match[g]     = valid_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
    assign valid_vec[g] = valid_q;
    assign vpn_arr[g]   = vpn_q;
    assign asid_arr[g]  = asid_q;
    assign ppn_arr[g]   = ppn_q;
    assign flags_arr[g] = flags_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_vpn   = vpn_arr[rd_idx];
  assign rd_asid  = asid_arr[rd_idx];
  assign rd_ppn   = ppn_arr[rd_idx];
  assign rd_flags = flags_arr[rd_idx];

endmodule

// File: rtl/xlat_resp.sv
module xlat_resp
  import xlat_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  seg_e             seg,
  input  logic             addr_err,
  input  logic             cam_hit,
  input  logic [PPN_W-1:0] cam_ppn,
  input  eflags_t          cam_flags,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_addr_err,
  output logic             rsp_prot_err,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_uncached
);

  localparam int DIR_W = VA_W - 3;

  logic            nxt_hit, nxt_miss, nxt_ae, nxt_pe, nxt_unc;
  logic [PA_W-1:0] nxt_pa;
  logic [PA_W-1:0] direct_pa;

  always_comb begin
    direct_pa = '0;
    direct_pa[DIR_W-1:0] = lk_vaddr[DIR_W-1:0];
  end

  always_comb begin
    nxt_hit  = 1'b0;
    nxt_miss = 1'b0;
    nxt_ae   = 1'b0;
    nxt_pe   = 1'b0;
    nxt_unc  = 1'b0;
    nxt_pa   = '0;
    if (lk_valid) begin
      if (addr_err) begin
        nxt_ae = 1'b1;
      end else begin
        case (seg)
          SEG_DIRECT_C: begin
            nxt_hit = 1'b1;
            nxt_pa  = direct_pa;
          end
          SEG_DIRECT_U: begin
            nxt_hit = 1'b1;
            nxt_pa  = direct_pa;
            nxt_unc = 1'b1;
          end
          default: begin
            if (!cam_hit) begin
              nxt_miss = 1'b1;
            end else if (lk_write && !cam_flags.wr_ok) begin
              nxt_pe = 1'b1;
            end else begin
              nxt_hit = 1'b1;
              nxt_pa  = {cam_ppn, lk_vaddr[OFF_W-1:0]};
              nxt_unc = cam_flags.nocache;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_prot_err <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= nxt_hit;
      rsp_miss     <= nxt_miss;
      rsp_addr_err <= nxt_ae;
      rsp_prot_err <= nxt_pe;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rsp_paddr    <= nxt_pa;
      rsp_uncached <= nxt_unc;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int VA_W    = VPN_W + OFF_W,
  parameter int PA_W    = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_addr_err,
  output logic              rsp_prot_err,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_uncached,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_writable,
  input  logic              fill_nocache,
  input  logic              fill_dirty,
  input  logic              fill_ref,
  input  logic              inv_one,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              inv_all,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [3:0]        rd_flags
);

  logic       rst_sync_n;
  seg_e       seg;
  logic       addr_err;
  logic       cam_lk_en;
  logic       cam_hit;
  logic [PPN_W-1:0] cam_ppn;
  eflags_t    cam_flags;
  eflags_t    fill_flags;
  eflags_t    rd_flags_s;

  xlat_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xlat_seg_decode u_seg (
    .top_bits  (lk_vaddr[VA_W-1 -: 3]),
    .user_mode (lk_user),
    .seg       (seg),
    .addr_err  (addr_err)
  );

  assign cam_lk_en  = lk_valid && !addr_err && (seg == SEG_MAPPED);
  assign fill_flags = '{dirty: fill_dirty, refd: fill_ref,
                        wr_ok: fill_writable, nocache: fill_nocache};

  xlat_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W),
    .PPN_W   (PPN_W)
  ) u_cam (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (fill_en),
    .wr_idx    (fill_idx),
    .wr_vpn    (fill_vpn),
    .wr_asid   (fill_asid),
    .wr_ppn    (fill_ppn),
    .wr_flags  (fill_flags),
    .inv_one   (inv_one),
    .inv_idx   (inv_idx),
    .inv_all   (inv_all),
    .lk_en     (cam_lk_en),
    .lk_write  (lk_write),
    .lk_vpn    (lk_vaddr[VA_W-1:OFF_W]),
    .lk_asid   (cur_asid),
    .hit       (cam_hit),
    .hit_ppn   (cam_ppn),
    .hit_flags (cam_flags),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_vpn    (rd_vpn),
    .rd_asid   (rd_asid),
    .rd_ppn    (rd_ppn),
    .rd_flags  (rd_flags_s)
  );

  assign rd_flags = rd_flags_s;

  xlat_resp #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFF_W (OFF_W),
    .PPN_W (PPN_W)
  ) u_resp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .lk_valid     (lk_valid),
    .lk_write     (lk_write),
    .lk_vaddr     (lk_vaddr),
    .seg          (seg),
    .addr_err     (addr_err),
    .cam_hit      (cam_hit),
    .cam_ppn      (cam_ppn),
    .cam_flags    (cam_flags),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_addr_err (rsp_addr_err),
    .rsp_prot_err (rsp_prot_err),
    .rsp_paddr    (rsp_paddr),
    .rsp_uncached (rsp_uncached)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_user,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_addr_err,
  input logic            rsp_prot_err,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_uncached,
  input logic            inv_all,
  input logic            rd_valid
);

  localparam int DIR_W = VA_W - 3;

  assert_one_outcome_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_addr_err, rsp_prot_err}));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_addr_err || rsp_prot_err));

  assert_rsp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |=> rsp_valid);

  assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_valid |=> !rsp_valid);

  assert_user_high_region_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && lk_user && lk_vaddr[VA_W-1]) |=> rsp_addr_err);

  assert_kernel_no_addr_err_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && !lk_user) |=> !rsp_addr_err);

  assert_direct_cached_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 3] == 3'b100) |=>
      (rsp_hit && !rsp_uncached && rsp_paddr[DIR_W-1:0] == $past(lk_vaddr[DIR_W-1:0])));

  assert_direct_uncached_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 3] == 3'b101) |=>
      (rsp_hit && rsp_uncached));

  assert_flush_all_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inv_all |=> !rd_valid);

endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .lk_user      (lk_user),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_addr_err (rsp_addr_err),
  .rsp_prot_err (rsp_prot_err),
  .rsp_paddr    (rsp_paddr),
  .rsp_uncached (rsp_uncached),
  .inv_all      (inv_all),
  .rd_valid     (rd_valid)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cur_asid;
  logic        lk_valid, lk_write, lk_user;
  logic [31:0] lk_vaddr;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_addr_err, rsp_prot_err, rsp_uncached;
  logic [31:0] rsp_paddr;
  logic        fill_en, fill_writable, fill_nocache, fill_dirty, fill_ref;
  logic [5:0]  fill_idx, fill_asid, inv_idx, rd_idx, rd_asid;
  logic [19:0] fill_vpn, fill_ppn, rd_vpn, rd_ppn;
  logic        inv_one, inv_all, rd_valid;
  logic [3:0]  rd_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_addr_err(rsp_addr_err), .rsp_prot_err(rsp_prot_err),
    .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_writable(fill_writable), .fill_nocache(fill_nocache),
    .fill_dirty(fill_dirty), .fill_ref(fill_ref),
    .inv_one(inv_one), .inv_idx(inv_idx), .inv_all(inv_all),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_asid(rd_asid),
    .rd_ppn(rd_ppn), .rd_flags(rd_flags)
  );

  // slot contents as a function of index
  function automatic logic [19:0] vpn_of(int i);
    return (i % 2 == 1 ? 20'hE0000 : 20'h00000) | 20'(i * 3 + 1);
  endfunction
  function automatic logic [5:0]  asid_of(int i); return 6'((i * 5) % 64); endfunction
  function automatic logic [19:0] ppn_of(int i);  return 20'(i * 1021 + 7); endfunction
  function automatic logic        wok_of(int i);  return (i % 3) != 0; endfunction
  function automatic logic        nc_of(int i);   return (i % 4) == 1; endfunction
  function automatic logic [11:0] off_of(int i);  return 12'((i * 97) % 4096); endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                      input logic [19:0] ppn, input logic wr, input logic nc);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 6'(idx); fill_vpn = vpn; fill_asid = asid;
    fill_ppn = ppn; fill_writable = wr; fill_nocache = nc;
    fill_dirty = 1'b0; fill_ref = 1'b0;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [5:0] asid,
                        input logic wr, input logic usr);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; cur_asid = asid; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // outcome vector order {hit, miss, addr_err, prot_err}
  task automatic expect_rsp(input string req, input logic [3:0] outc,
                            input logic [31:0] pa, input logic unc);
    logic [3:0] act;
    act = {rsp_hit, rsp_miss, rsp_addr_err, rsp_prot_err};
    check(rsp_valid && act == outc, req, "outcome", {rsp_valid, act}, {1'b1, outc});
    if (outc[3]) begin
      check(rsp_paddr == pa, req, "paddr", rsp_paddr, pa);
      check(rsp_uncached == unc, req, "uncached", rsp_uncached, unc);
    end
    if (outc[2]) check(rsp_paddr == 32'h0, req, "miss paddr", rsp_paddr, 0);
  endtask

  task automatic read_slot(input int idx);
    rd_idx = 6'(idx);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cur_asid = '0; lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_user = 0;
    fill_en = 0; fill_idx = '0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0;
    fill_writable = 0; fill_nocache = 0; fill_dirty = 0; fill_ref = 0;
    inv_one = 0; inv_idx = '0; inv_all = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R14: reset state
    check(!rsp_valid, "R14", "rsp_valid in reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rsp_valid, "R14", "rsp_valid after reset", rsp_valid, 0);
    for (int i = 0; i < 64; i++) begin
      read_slot(i);
      check(!rd_valid, "R14", "slot valid after reset", rd_valid, 0);
    end

    // R1: fill every slot and read it back
    for (int i = 0; i < 64; i++) fill(i, vpn_of(i), asid_of(i), ppn_of(i), wok_of(i), nc_of(i));
    for (int i = 0; i < 64; i++) begin
      read_slot(i);
      check(rd_valid && rd_vpn == vpn_of(i) && rd_asid == asid_of(i) && rd_ppn == ppn_of(i),
            "R1", "slot fields", {rd_valid, rd_vpn, rd_asid, rd_ppn},
            {1'b1, vpn_of(i), asid_of(i), ppn_of(i)});
      check(rd_flags == {2'b00, wok_of(i), nc_of(i)}, "R1", "slot flags",
            rd_flags, {2'b00, wok_of(i), nc_of(i)});
    end

    // R8: user access to upper kernel slots
    for (int i = 1; i < 64; i += 2) begin
      lookup({vpn_of(i), off_of(i)}, asid_of(i), 1'b0, 1'b1);
      expect_rsp("R8", 4'b0010, 0, 0);
      read_slot(i);
      check(rd_flags[2] == 1'b0, "R8", "ref untouched", rd_flags[2], 0);
    end

    // R3/R4: wrong identifier misses and leaves slots alone
    for (int i = 0; i < 64; i++) begin
      lookup({vpn_of(i), off_of(i)}, asid_of(i) ^ 6'h01, 1'b0, 1'b0);
      expect_rsp("R3", 4'b0100, 0, 0);
      read_slot(i);
      check(rd_flags[2] == 1'b0, "R4", "ref after miss", rd_flags[2], 0);
    end

    // R2/R7/R10: kernel reads hit, user reads hit even slots
    for (int i = 0; i < 64; i++) begin
      lookup({vpn_of(i), off_of(i)}, asid_of(i), 1'b0, 1'b0);
      expect_rsp("R2", 4'b1000, {ppn_of(i), off_of(i)}, nc_of(i));
      if (i % 2 == 0) begin
        lookup({vpn_of(i), off_of(i) ^ 12'hFFF}, asid_of(i), 1'b0, 1'b1);
        expect_rsp("R7", 4'b1000, {ppn_of(i), off_of(i) ^ 12'hFFF}, nc_of(i));
      end
      read_slot(i);
      check(rd_flags[3:2] == 2'b01, "R10", "ref set dirty clear", rd_flags[3:2], 2'b01);
    end

    // R9/R10: stores
    for (int i = 0; i < 64; i++) begin
      lookup({vpn_of(i), off_of(i)}, asid_of(i), 1'b1, 1'b0);
      if (wok_of(i)) expect_rsp("R10", 4'b1000, {ppn_of(i), off_of(i)}, nc_of(i));
      else           expect_rsp("R9", 4'b0001, 0, 0);
      read_slot(i);
      check(rd_flags[3] == wok_of(i), wok_of(i) ? "R10" : "R9", "dirty after store",
            rd_flags[3], wok_of(i));
    end

    // R5/R6/R8: direct regions
    for (int k = 0; k < 32; k++) begin
      logic [28:0] low;
      low = 29'(k * 16777259 + 5);
      lookup({3'b100, low}, 6'h00, k[0], 1'b0);
      expect_rsp("R5", 4'b1000, {3'b000, low}, 1'b0);
      lookup({3'b101, low}, 6'h00, k[0], 1'b0);
      expect_rsp("R6", 4'b1000, {3'b000, low}, 1'b1);
      lookup({k[0] ? 3'b101 : 3'b100, low}, 6'h00, 1'b0, 1'b1);
      expect_rsp("R8", 4'b0010, 0, 0);
    end

    // R5: a slot holding a direct-region page is bypassed
    fill(20, 20'h80001, 6'h00, 20'h55555, 1'b1, 1'b1);
    lookup({20'h80001, 12'h123}, 6'h00, 1'b0, 1'b0);
    expect_rsp("R5", 4'b1000, {3'b000, 17'h00001, 12'h123}, 1'b0);
    read_slot(20);
    check(rd_flags[2] == 1'b0, "R5", "bypassed slot ref", rd_flags[2], 0);

    // R2: lowest index wins on overlap; R11: single invalidate
    fill(3,  20'h12345, 6'd9, 20'hAAAAA, 1'b1, 1'b0);
    fill(10, 20'h12345, 6'd9, 20'hBBBBB, 1'b1, 1'b0);
    lookup({20'h12345, 12'h042}, 6'd9, 1'b0, 1'b0);
    expect_rsp("R2", 4'b1000, {20'hAAAAA, 12'h042}, 1'b0);
    @(negedge clk); inv_one = 1'b1; inv_idx = 6'd3;
    @(negedge clk); inv_one = 1'b0;
    read_slot(3);
    check(!rd_valid, "R11", "slot 3 invalid", rd_valid, 0);
    lookup({20'h12345, 12'h042}, 6'd9, 1'b0, 1'b0);
    expect_rsp("R11", 4'b1000, {20'hBBBBB, 12'h042}, 1'b0);

    // R12: collisions
    @(negedge clk); inv_all = 1'b1; fill_en = 1'b1; fill_idx = 6'd5;
    fill_vpn = 20'h00777; fill_asid = 6'd1; fill_ppn = 20'h00777;
    @(negedge clk); inv_all = 1'b0; fill_en = 1'b0;
    read_slot(5);
    check(!rd_valid, "R12", "global beats fill", rd_valid, 0);
    @(negedge clk); inv_one = 1'b1; inv_idx = 6'd6; fill_en = 1'b1; fill_idx = 6'd6;
    @(negedge clk); inv_one = 1'b0; fill_en = 1'b0;
    read_slot(6);
    check(rd_valid, "R12", "fill beats single", rd_valid, 1);
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    for (int i = 0; i < 64; i++) begin
      read_slot(i);
      check(!rd_valid, "R12", "slot after global invalidate", rd_valid, 0);
    end
    lookup({20'h12345, 12'h042}, 6'd9, 1'b0, 1'b0);
    expect_rsp("R12", 4'b0100, 0, 0);

    // R13: no request, no response
    @(negedge clk);
    check(!rsp_valid && !rsp_hit && !rsp_miss, "R13", "idle response",
          {rsp_valid, rsp_hit, rsp_miss}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule